// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes in serial words on a data line. The bit timing comes from a clock that an external master drives, so the block is always the clock slave. The external clock and data pins are brought into the system clock domain through a chain of synchronizer flops. A falling-edge detector then takes one data bit per external clock period, least significant bit first. A word is 8 bits long, or 9 bits when the wide-word bit is set.

When the last bit of a word arrives, the word moves from the shift register into a holding register. A receive-full flag is then set, and an interrupt line follows that flag if the interrupt is enabled. Software uses a small register port. It reads the control/status register first, which holds the ninth bit and the overrun flag, and then reads the data register. Reading the data register empties the holding register. If a word completes while the holding register is still full, that word is dropped, overrun is flagged and reception stalls. The only way to recover is to clear the continuous-receive bit.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the interrupt register (address 2) reads 0x00, and `irq` and `rx_full` are low.
- R2: A word is taken in only while both control bit 7 (port enable) and control bit 4 (continuous receive) are 1. External clock edges at any other time leave `rx_full` low and the data register unchanged.
- R3: Control bit 5 (single receive) can be written and read back but has no effect. With it set and bit 4 clear, no word is received.
- R4: Data is sampled on each falling edge of `ser_clk`, least significant bit first. After 8 edges (control bit 6 = 0) the word is readable at address 1 and `rx_full` (also readable as bit 7 of address 2) is 1.
- R5: With control bit 6 = 1, a word is 9 bits long. Its ninth bit reads as control bit 0 and its low eight bits read at address 1. An 8-bit word sets control bit 0 to 0.
- R6: `irq` is high exactly when `rx_full` is high and bit 0 of address 2 (interrupt enable) is 1.
- R7: A read of address 1 clears `rx_full`. Reads of addresses 0 and 2 have no side effect.
- R8: When a word completes while `rx_full` is 1, control bit 1 (overrun) becomes 1 and the data register keeps the earlier word. No further word is accepted while overrun is 1.
- R9: Overrun survives a read of address 1. It is cleared only by writing 0 to control bit 4.
- R10: Clearing control bit 4 throws away any partly received bits. The next word after re-enabling starts at bit 0.
- R11: Control bit 2 always reads 0. Control bit 3 can be written and read back but does not change reception. Writes to control bits 2..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register select: 0 control/status, 1 data, 2 interrupt |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| ser_clk | input | 1 | External master clock, idle high |
| ser_data | input | 1 | Serial data line |
| rx_full | output | 1 | Holding register holds an unread word |
| irq | output | 1 | Receive interrupt |

## Verification
Most internal faults in this block show up as a wrong word at address 1 once the word completes, a few system clocks after the last external falling edge. A bit counter that is off by one rotates or truncates the value. A wrong word-length decode moves the ninth bit or leaves it stale. Faults in the overrun logic appear only on the next completed word or the next control write: a dropped word overwrites held data, a stuck stall never lifts, or a partial word left over from before a disable corrupts the first word after re-enabling. The bench therefore reads the data register after each word and runs words back to back across every enable change.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_IRQ  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CB_PORT   = 7;
  localparam int CB_WIDE   = 6;
  localparam int CB_SINGLE = 5;
  localparam int CB_CONT   = 4;
  localparam int CB_ADET   = 3;
  localparam int CB_FRAME  = 2;
  localparam int CB_OVR    = 1;
  localparam int CB_BIT9   = 0;

  // Index of the final bit of a word for the chosen length.
  function automatic int unsigned last_index(input logic wide, input int unsigned base_w);
    return wide ? base_w : base_w - 1;
  endfunction

  // Place one serial bit at position idx of a partial word.
  function automatic logic [15:0] place_bit(input logic [15:0] partial,
                                             input logic bit_in,
                                             input int unsigned idx);
    logic [15:0] r;
    r = partial;
    r[idx[3:0]] = bit_in;
    return r;
  endfunction

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic ext_data,
  output logic fall_pulse,
  output logic data_sync
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ck_q[0] <= 1'b1;
          dt_q[0] <= 1'b0;
        end else begin
          ck_q[0] <= ext_clk;
          dt_q[0] <= ext_data;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ck_q[g] <= 1'b1;
          dt_q[g] <= 1'b0;
        end else begin
          ck_q[g] <= ck_q[g-1];
          dt_q[g] <= dt_q[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev <= 1'b1;
    else        ck_prev <= ck_q[STAGES-1];
  end

  assign fall_pulse = ck_prev & ~ck_q[STAGES-1];
  assign data_sync  = dt_q[STAGES-1];

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wide,
  input  logic              fall,
  input  logic              din,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [15:0]       next_word;
  logic              at_last;

  assign next_word = place_bit({{(16-WORD_W){1'b0}}, shreg}, din, int'(cnt));
  assign at_last   = (int'(cnt) == last_index(wide, DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
      done  <= 1'b0;
      word  <= '0;
    end else if (!run) begin
      cnt   <= '0;
      shreg <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fall) begin
        if (at_last) begin
          word  <= next_word[WORD_W-1:0];
          done  <= 1'b1;
          cnt   <= '0;
          shreg <= '0;
        end else begin
          shreg <= next_word[WORD_W-1:0];
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && shreg == '0));
  a_r4_done_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall && run));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DATA_W);
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  output logic              run,
  output logic              wide,
  output logic              full,
  output logic              irq
);
  logic              port_en, single, cont, adet, ovr, bit9, ie;
  logic [DATA_W-1:0] hold;
  logic              data_read, wr_ctrl, wr_irq, accept, drop;

  assign data_read = reg_rd && reg_sel_e'(reg_addr) == SEL_DATA;
  assign wr_ctrl   = reg_wr && reg_sel_e'(reg_addr) == SEL_CTRL;
  assign wr_irq    = reg_wr && reg_sel_e'(reg_addr) == SEL_IRQ;
  assign accept    = done && (!full || data_read);
  assign drop      = done && full && !data_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en <= 1'b0; wide <= 1'b0; single <= 1'b0; cont <= 1'b0;
      adet <= 1'b0; ovr <= 1'b0; bit9 <= 1'b0; ie <= 1'b0;
      full <= 1'b0; hold <= '0;
    end else begin
      if (wr_ctrl) begin
        port_en <= reg_wdata[CB_PORT];
        wide    <= reg_wdata[CB_WIDE];
        single  <= reg_wdata[CB_SINGLE];
        cont    <= reg_wdata[CB_CONT];
        adet    <= reg_wdata[CB_ADET];
      end
      if (wr_irq) ie <= reg_wdata[0];
      if (data_read) full <= 1'b0;
      if (accept) begin
        hold <= word[DATA_W-1:0];
        bit9 <= wide ? word[DATA_W] : 1'b0;
        full <= 1'b1;
      end
      if (drop) ovr <= 1'b1;
      if (!cont) ovr <= 1'b0;
    end
  end

  assign run = port_en && cont && !ovr;
  assign irq = full && ie;

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_sel_e'(reg_addr))
      SEL_CTRL: reg_rdata = {port_en, wide, single, cont, adet, 1'b0, ovr, bit9};
      SEL_DATA: reg_rdata[DATA_W-1:0] = hold;
      SEL_IRQ:  reg_rdata = {full, 6'b0, ie};
      default:  reg_rdata = 8'h00;
    endcase
  end

  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cont |=> !ovr);
  a_r8_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(full));
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && $past(ovr)) |-> $stable(hold));
  a_r7_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(data_read));
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ser_clk,
  input  logic       ser_data,
  output logic       rx_full,
  output logic       irq
);
  localparam int WORD_W = DATA_W + 1;

  logic              fall_evt, data_s, run, wide, word_done;
  logic [WORD_W-1:0] word;

  rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_clk(ser_clk), .ext_data(ser_data),
    .fall_pulse(fall_evt), .data_sync(data_s)
  );

  rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .wide(wide), .fall(fall_evt),
    .din(data_s), .done(word_done), .word(word)
  );

  rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done(word_done), .word(word), .run(run), .wide(wide),
    .full(rx_full), .irq(irq)
  );

  a_r6_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_full);
  a_r2_done_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(run));
endmodule

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       ser_clk = 1, ser_data = 0;
  logic       rx_full, irq;
  int         checks = 0, errors = 0;
  logic [8:0] expq[$];
  logic [7:0] r;

  always #2 clk = ~clk;

  sync_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_clk(ser_clk), .ser_data(ser_data), .rx_full(rx_full), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send_bits(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_data = v[i];
      repeat (4) @(negedge clk);
      ser_clk = 0;
      repeat (4) @(negedge clk);
      ser_clk = 1;
    end
    repeat (8) @(negedge clk);
  endtask

  // Driver: sends a word and queues the value the data port must show.
  task automatic drive_word(input logic [8:0] v, input int n, input bit expect_it);
    if (expect_it) expq.push_back(n == 9 ? v : {1'b0, v[7:0]});
    send_bits(v, n);
  endtask

  // Monitor side: reads bit 9 and data, compares against the queue head.
  task automatic take_word(input string req);
    logic [8:0] e;
    logic [7:0] c, d;
    e = expq.pop_front();
    rd(2'd0, c);
    rd(2'd1, d);
    chk(req, {c[0], d}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(2'd0, r); chk("R1 ctrl", r, 8'h00);
    peek(2'd2, r); chk("R1 irqreg", r, 8'h00);
    chk("R1 irq", irq, 0); chk("R1 full", rx_full, 0);

    // R3 single-receive bit alone does nothing
    wr(2'd0, 8'hA0);
    drive_word(9'h0A5, 8, 0);
    chk("R3 full", rx_full, 0);
    peek(2'd0, r); chk("R3 readback", r, 8'hA0);
    // R2 continuous enable without port enable
    wr(2'd0, 8'h10);
    drive_word(9'h0A5, 8, 0);
    chk("R2 no port", rx_full, 0);
    peek(2'd1, r); chk("R2 data", r, 8'h00);

    // R4/R6/R7 basic 8-bit word
    wr(2'd0, 8'h90); wr(2'd2, 8'h01);
    drive_word(9'h03C, 8, 1);
    chk("R4 full", rx_full, 1);
    chk("R6 irq", irq, 1);
    peek(2'd2, r); chk("R4 flag bit", r, 8'h81);
    wr(2'd2, 8'h00); chk("R6 irq masked", irq, 0);
    wr(2'd2, 8'h01);
    take_word("R4 R5 word");
    chk("R7 full cleared", rx_full, 0); chk("R7 irq", irq, 0);
    drive_word(9'h0E1, 8, 1);
    take_word("R4 word2");

    // R5 nine-bit
    wr(2'd0, 8'hD0);
    drive_word(9'h15A, 9, 1);
    take_word("R5 ninth set");
    drive_word(9'h0C3, 9, 1);
    take_word("R5 ninth clear");

    // R8/R9 overrun
    wr(2'd0, 8'h90);
    drive_word(9'h011, 8, 1);
    drive_word(9'h022, 8, 0);
    peek(2'd0, r); chk("R8 ovr", r[1], 1);
    take_word("R8 kept first");
    drive_word(9'h033, 8, 0);
    chk("R8 stalled", rx_full, 0);
    peek(2'd0, r); chk("R9 survives read", r[1], 1);
    wr(2'd0, 8'h80);
    peek(2'd0, r); chk("R9 cleared", r[1], 0);
    wr(2'd0, 8'h90);
    drive_word(9'h044, 8, 1);
    take_word("R9 resumed");

    // R10 partial word discarded
    send_bits(9'h007, 3);
    wr(2'd0, 8'h80); wr(2'd0, 8'h90);
    drive_word(9'h096, 8, 1);
    take_word("R10 aligned");

    // R11 ignored bits, address-detect no effect
    wr(2'd0, 8'hFF);
    peek(2'd0, r); chk("R11 readback", r, 8'hF8);
    wr(2'd0, 8'h9F);
    peek(2'd0, r); chk("R11 adet stored", r, 8'h98);
    drive_word(9'h05C, 8, 1);
    take_word("R11 adet no effect");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule